// File: doc/BRIEF.md
# IN Endpoint Transaction Responder

This block is the device-side handshake and control engine for a single USB IN endpoint. Firmware loads a packet into a local byte buffer, writes the byte count and then clears the NACK control bit to arm the endpoint. When the token decoder reports an IN token for this endpoint, the block answers in one of three ways. It returns a one-byte STALL handshake, or a one-byte NAK handshake, or it streams the buffered packet to the serializer as a data PID byte followed by the payload bytes. In the last case it then listens for the host's ACK.

A received ACK completes the transfer. The data toggle flips, NACK is set again so the endpoint goes quiet, and an interrupt is raised for firmware. The host may not answer within a programmable turnaround window, counted in bit-time strobes. In that case the attempt is dropped and nothing changes, so the next IN token gets the identical packet with the identical PID. Bit coding, CRC and token decoding are done elsewhere.

Top module: `usb_in_ep_responder`

## Requirements
- R1: With STALL=0 and NACK=0, an IN token seen while idle makes the block emit one data PID byte and then exactly `count` buffer bytes in ascending address order. `tx_last` is high only on the final byte.
- R2: With STALL=0 and NACK=1, an IN token makes the block emit a single byte 0x5A (NAK) with `tx_last` high, and no data.
- R3: With STALL=1, an IN token makes the block emit a single byte 0x1E (STALL) with `tx_last` high, whatever the NACK bit holds.
- R4: The data PID byte is 0xC3 (DATA0) when the toggle is 0 and 0x4B (DATA1) when it is 1. A count of 0 sends only the PID byte, with `tx_last` high.
- R5: An `hs_ack` pulse while the block waits for the host's handshake after a data packet flips the toggle, sets NACK to 1 and sets `irq` to 1.
- R6: In the handshake wait, each `bit_tick` advances a counter, and the wait is abandoned on the tick that reaches the timeout value. An abandoned attempt leaves toggle, NACK and `irq` unchanged. The next IN token resends the same bytes with the same PID.
- R7: The timeout register (address 2) stores writes clamped to the range 16..18, and its reset value is 16. An ACK in the same cycle as the final timeout tick is still accepted.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R9: `irq` stays high until a write to the control register (address 0) with bit 3 set. A control write with bit 3 clear leaves `irq` unchanged.
- R10: IN tokens that arrive while a reply is in progress or during the handshake wait are ignored. `hs_ack` outside the handshake wait has no effect.
- R11: A write to the count register (address 1) of a value above DEPTH stores DEPTH.
- R12: A control write (address 0) loads NACK from bit 0, STALL from bit 1 and the toggle from bit 2. Reset leaves NACK=1, STALL=0, toggle=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_in | input | 1 | One-cycle pulse: IN token decoded for this endpoint |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| hs_ack | input | 1 | One-cycle pulse: ACK handshake received from host |
| tx_ready | input | 1 | Serializer accepts the current byte |
| tx_valid | output | 1 | A byte is offered to the serializer |
| tx_data | output | 8 | Offered byte (PID or payload) |
| tx_last | output | 1 | Offered byte ends the packet |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 count, 2 timeout |
| reg_wdata | input | 8 | Register write data |
| buf_we | input | 1 | Buffer write strobe |
| buf_addr | input | AW | Buffer write address |
| buf_wdata | input | 8 | Buffer write data |
| ep_nack | output | 1 | Current NACK bit |
| ep_stall | output | 1 | Current STALL bit |
| ep_toggle | output | 1 | Current data toggle |
| irq | output | 1 | Endpoint interrupt |

## Verification
The bench targets the following cases:
- Both STALL and NACK set: a design with the priority reversed would return NAK.
- A zero-count packet: a wrong design would emit a stray payload byte or leave `tx_last` low.
- A host that stays silent: a design that updated state on a timeout would flip the toggle early and resend with the wrong PID.
- The timeout window at its edges, with the ACK placed on the final tick and with the timeout register written outside its range: an off-by-one counter or a missing clamp would accept an ACK one tick late or drop one that is on time.
- Serializer back-pressure and tokens or ACKs that arrive at the wrong time: a design that mishandled them would drop bytes or restart a reply.
- Count writes above DEPTH.
- Writes that leave the interrupt alone.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    localparam logic [7:0] PID_DATA0 = 8'hC3;
    localparam logic [7:0] PID_DATA1 = 8'h4B;
    localparam logic [7:0] PID_NAK   = 8'h5A;
    localparam logic [7:0] PID_STALL = 8'h1E;

    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_COUNT = 2'd1;
    localparam logic [1:0] RA_TMO   = 2'd2;

    localparam int CB_NACK   = 0;
    localparam int CB_STALL  = 1;
    localparam int CB_TOGGLE = 2;
    localparam int CB_IRQCLR = 3;

    localparam int TMO_MIN = 16;
    localparam int TMO_MAX = 18;
    localparam int TMO_W   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HS,
        ST_PID,
        ST_DATA,
        ST_WAIT
    } ep_state_e;

    typedef struct packed {
        logic nack;
        logic stall;
        logic toggle;
        logic irq;
    } ep_ctl_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
    } tx_beat_t;

    function automatic logic [7:0] data_pid(input logic tog);
        return tog ? PID_DATA1 : PID_DATA0;
    endfunction

    function automatic logic [TMO_W-1:0] clamp_tmo(input logic [7:0] v);
        if (v < 8'(TMO_MIN)) return TMO_W'(TMO_MIN);
        if (v > 8'(TMO_MAX)) return TMO_W'(TMO_MAX);
        return v[TMO_W-1:0];
    endfunction

endpackage

// File: rtl/ep_tx_buffer.sv
module ep_tx_buffer #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ep_ctrl_regs.sv
module ep_ctrl_regs
    import usb_in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             hw_ack,
    output ep_ctl_t          ctl,
    output logic [CNT_W-1:0] cnt,
    output logic [TMO_W-1:0] tmo
);
    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.nack   <= 1'b1;
            ctl.stall  <= 1'b0;
            ctl.toggle <= 1'b0;
            ctl.irq    <= 1'b0;
            cnt        <= '0;
            tmo        <= TMO_W'(TMO_MIN);
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    RA_CTRL: begin
                        ctl.nack   <= reg_wdata[CB_NACK];
                        ctl.stall  <= reg_wdata[CB_STALL];
                        ctl.toggle <= reg_wdata[CB_TOGGLE];
                        if (reg_wdata[CB_IRQCLR]) ctl.irq <= 1'b0;
                    end
                    RA_COUNT: begin
                        if (int'(reg_wdata) > DEPTH) cnt <= CNT_W'(DEPTH);
                        else                         cnt <= CNT_W'(reg_wdata);
                    end
                    RA_TMO:  tmo <= clamp_tmo(reg_wdata);
                    default: ;
                endcase
            end
            // Hardware completion overrides a same-cycle firmware write.
            if (hw_ack) begin
                ctl.toggle <= ~ctl.toggle;
                ctl.nack   <= 1'b1;
                ctl.irq    <= 1'b1;
            end
        end
    end

    // R5: a completed handshake closes the endpoint and signals firmware
    assert_ack_update_R5: assert property (@(posedge clk) disable iff (rst)
        hw_ack |=> ctl.nack && ctl.irq && (ctl.toggle != $past(ctl.toggle)));

    // R6: toggle moves only on ACK or on a control write
    assert_toggle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !hw_ack && !ctrl_wr |=> $stable(ctl.toggle));

    // R9: interrupt is sticky until cleared
    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.irq && !(ctrl_wr && reg_wdata[CB_IRQCLR]) |=> ctl.irq);

    assert_tmo_range_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(tmo) >= TMO_MIN) && (int'(tmo) <= TMO_MAX));

    assert_cnt_range_R11: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DEPTH);
endmodule

// File: rtl/ep_txn_fsm.sv
module ep_txn_fsm
    import usb_in_ep_pkg::*;
#(
    parameter int AW    = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_in,
    input  logic             hs_ack,
    input  logic             bit_tick,
    input  logic             tx_ready,
    input  logic             nack,
    input  logic             stall,
    input  logic             toggle,
    input  logic [CNT_W-1:0] cnt,
    input  logic [TMO_W-1:0] tmo,
    input  logic [7:0]       rd_data,
    output logic [AW-1:0]    rd_addr,
    output tx_beat_t         beat,
    output logic             ack_evt
);
    ep_state_e        state;
    logic [CNT_W-1:0] idx;
    logic [TMO_W-1:0] ticks;
    logic [7:0]       hs_pid;
    logic             data_end;

    assign rd_addr  = idx[AW-1:0];
    assign data_end = ({1'b0, idx} + 1'b1) == {1'b0, cnt};
    assign ack_evt  = (state == ST_WAIT) && hs_ack;

    always_comb begin
        beat = '0;
        case (state)
            ST_HS: begin
                beat.valid = 1'b1;
                beat.data  = hs_pid;
                beat.last  = 1'b1;
            end
            ST_PID: begin
                beat.valid = 1'b1;
                beat.data  = data_pid(toggle);
                beat.last  = (cnt == '0);
            end
            ST_DATA: begin
                beat.valid = 1'b1;
                beat.data  = rd_data;
                beat.last  = data_end;
            end
            default: beat = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            ticks  <= '0;
            hs_pid <= PID_NAK;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (tok_in) begin
                        if (stall) begin
                            hs_pid <= PID_STALL;
                            state  <= ST_HS;
                        end else if (nack) begin
                            hs_pid <= PID_NAK;
                            state  <= ST_HS;
                        end else begin
                            state <= ST_PID;
                        end
                    end
                end
                ST_HS: begin
                    if (tx_ready) state <= ST_IDLE;
                end
                ST_PID: begin
                    if (tx_ready) begin
                        idx   <= '0;
                        ticks <= '0;
                        state <= (cnt == '0) ? ST_WAIT : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (tx_ready) begin
                        if (data_end) begin
                            ticks <= '0;
                            state <= ST_WAIT;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (hs_ack) begin
                        state <= ST_IDLE;
                    end else if (bit_tick) begin
                        if ((ticks + 1'b1) == tmo) state <= ST_IDLE;
                        else                      ticks <= ticks + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_nak_reply_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && tok_in && !stall && nack
        |=> beat.valid && beat.last && (beat.data == PID_NAK));

    assert_stall_reply_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && tok_in && stall
        |=> beat.valid && beat.last && (beat.data == PID_STALL));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        beat.valid && !tx_ready
        |=> beat.valid && $stable(beat.data) && $stable(beat.last));

    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) && !hs_ack && !bit_tick |=> (state == ST_WAIT));

    assert_busy_ignores_tok_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HS) && tok_in && !tx_ready |=> (state == ST_HS));
endmodule

// File: rtl/usb_in_ep_responder.sv
module usb_in_ep_responder
    import usb_in_ep_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_in,
    input  logic          bit_tick,
    input  logic          hs_ack,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    output logic          ep_nack,
    output logic          ep_stall,
    output logic          ep_toggle,
    output logic          irq
);
    ep_ctl_t          ctl;
    logic [CNT_W-1:0] cnt;
    logic [TMO_W-1:0] tmo;
    logic [AW-1:0]    rd_addr;
    logic [7:0]       rd_data;
    logic             ack_evt;
    tx_beat_t         beat;

    ep_tx_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_addr),
        .wdata (buf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    ep_ctrl_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hw_ack    (ack_evt),
        .ctl       (ctl),
        .cnt       (cnt),
        .tmo       (tmo)
    );

    ep_txn_fsm #(.AW(AW), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tok_in   (tok_in),
        .hs_ack   (hs_ack),
        .bit_tick (bit_tick),
        .tx_ready (tx_ready),
        .nack     (ctl.nack),
        .stall    (ctl.stall),
        .toggle   (ctl.toggle),
        .cnt      (cnt),
        .tmo      (tmo),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .beat     (beat),
        .ack_evt  (ack_evt)
    );

    assign tx_valid  = beat.valid;
    assign tx_data   = beat.data;
    assign tx_last   = beat.last;
    assign ep_nack   = ctl.nack;
    assign ep_stall  = ctl.stall;
    assign ep_toggle = ctl.toggle;
    assign irq       = ctl.irq;
endmodule

// File: tb/usb_in_ep_responder_tb.sv
module usb_in_ep_responder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic clk = 0, rst = 1;
    logic tok_in = 0, bit_tick = 0, hs_ack = 0, tx_ready = 0;
    logic tx_valid, tx_last;
    logic [7:0] tx_data;
    logic reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic buf_we = 0;
    logic [AW-1:0] buf_addr = 0;
    logic [7:0] buf_wdata = 0;
    logic ep_nack, ep_stall, ep_toggle, irq;

    int errors = 0, checks = 0;
    string cur_req = "R12";

    usb_in_ep_responder #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .tok_in(tok_in), .bit_tick(bit_tick),
        .hs_ack(hs_ack), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .ep_nack(ep_nack),
        .ep_stall(ep_stall), .ep_toggle(ep_toggle), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] mbuf [DEPTH];
    logic [7:0] mq [$];
    int  m_cnt, m_tmo, m_ticks;
    bit  m_nack, m_stall, m_tog, m_irq, m_wait, m_isdata, m_ackhit;

    always @(posedge clk) begin
        if (rst) begin
            m_nack = 1; m_stall = 0; m_tog = 0; m_irq = 0;
            m_cnt = 0; m_tmo = 16; m_wait = 0; m_isdata = 0; m_ticks = 0;
            mq.delete();
        end else begin
            m_ackhit = 0;
            if (mq.size() > 0) begin
                if (tx_ready) begin
                    void'(mq.pop_front());
                    if (mq.size() == 0 && m_isdata) begin
                        m_wait = 1; m_ticks = 0;
                    end
                end
            end else if (m_wait) begin
                if (hs_ack) begin
                    m_ackhit = 1; m_wait = 0;
                end else if (bit_tick) begin
                    m_ticks++;
                    if (m_ticks == m_tmo) m_wait = 0;
                end
            end else if (tok_in) begin
                if (m_stall) begin
                    mq.push_back(8'h1E); m_isdata = 0;
                end else if (m_nack) begin
                    mq.push_back(8'h5A); m_isdata = 0;
                end else begin
                    mq.push_back(m_tog ? 8'h4B : 8'hC3);
                    for (int i = 0; i < m_cnt; i++) mq.push_back(mbuf[i]);
                    m_isdata = 1;
                end
            end
            if (reg_we) begin
                if (reg_addr == 0) begin
                    m_nack = reg_wdata[0]; m_stall = reg_wdata[1]; m_tog = reg_wdata[2];
                    if (reg_wdata[3]) m_irq = 0;
                end else if (reg_addr == 1) begin
                    m_cnt = (reg_wdata > DEPTH) ? DEPTH : int'(reg_wdata);
                end else if (reg_addr == 2) begin
                    m_tmo = (reg_wdata < 16) ? 16 : (reg_wdata > 18) ? 18 : int'(reg_wdata);
                end
            end
            if (buf_we) mbuf[buf_addr] = buf_wdata;
            if (m_ackhit) begin
                m_tog = !m_tog; m_nack = 1; m_irq = 1;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_req, "tx_valid", int'(tx_valid), int'(mq.size() > 0));
            if (mq.size() > 0) begin
                chk(cur_req, "tx_data", int'(tx_data), int'(mq[0]));
                chk(cur_req, "tx_last", int'(tx_last), int'(mq.size() == 1));
            end
            chk(cur_req, "nack", int'(ep_nack), int'(m_nack));
            chk(cur_req, "stall", int'(ep_stall), int'(m_stall));
            chk(cur_req, "toggle", int'(ep_toggle), int'(m_tog));
            chk(cur_req, "irq", int'(irq), int'(m_irq));
        end
    end

    // stream capture: outputs from negedge paired with the ready driven for the next edge
    logic [8:0] got [$];
    always @(negedge clk) begin
        #2;
        if (tx_valid && tx_ready) got.push_back({tx_last, tx_data});
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d; cyc(); reg_we = 0;
    endtask
    task automatic wr_buf(input int a, input logic [7:0] d);
        buf_we = 1; buf_addr = AW'(a); buf_wdata = d; cyc(); buf_we = 0;
    endtask
    task automatic token();
        tok_in = 1; cyc(); tok_in = 0;
    endtask
    task automatic drain();
        tx_ready = 1;
        for (int k = 0; k < 300; k++) begin
            cyc();
            if (!tx_valid) break;
        end
    endtask
    task automatic ticks(input int n);
        bit_tick = 1;
        repeat (n) cyc();
        bit_tick = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 0; cyc();
        // R12 reset state
        chk("R12", "reset nack", int'(ep_nack), 1);
        chk("R12", "reset stall", int'(ep_stall), 0);
        chk("R12", "reset toggle", int'(ep_toggle), 0);
        chk("R12", "reset irq", int'(irq), 0);
        chk("R12", "reset tx_valid", int'(tx_valid), 0);

        // R1 / R4: five-byte DATA0 packet
        cur_req = "R1";
        for (int i = 0; i < 5; i++) wr_buf(i, 8'(8'h10 + i * 3));
        wr_reg(1, 5);
        wr_reg(0, 8'h00);
        got.delete();
        token(); drain();
        chk("R1", "byte count", got.size(), 6);
        if (got.size() == 6) begin
            chk("R4", "DATA0 pid", int'(got[0]), 9'h0C3);
            for (int i = 1; i < 6; i++)
                chk("R1", "payload", int'(got[i]), int'({(i == 5) ? 1'b1 : 1'b0, 8'(8'h10 + (i - 1) * 3)}));
        end

        // R5: ACK completes the transfer
        cur_req = "R5";
        hs_ack = 1; cyc(); hs_ack = 0; cyc();
        chk("R5", "toggle after ack", int'(ep_toggle), 1);
        chk("R5", "nack after ack", int'(ep_nack), 1);
        chk("R5", "irq after ack", int'(irq), 1);

        // R2: NAK when closed
        cur_req = "R2";
        got.delete(); token(); drain();
        chk("R2", "nak reply", got.size() == 1 ? int'(got[0]) : -1, 9'h15A);

        // R3: STALL beats NACK; R12 control bit positions
        cur_req = "R3";
        wr_reg(0, 8'h07);
        chk("R12", "stall bit", int'(ep_stall), 1);
        got.delete(); token(); drain();
        chk("R3", "stall reply", got.size() == 1 ? int'(got[0]) : -1, 9'h11E);

        // R9: irq sticky, W1C
        cur_req = "R9";
        wr_reg(0, 8'h04);
        chk("R9", "irq kept", int'(irq), 1);
        wr_reg(0, 8'h0C);
        chk("R9", "irq cleared", int'(irq), 0);

        // R4 zero-length DATA1, R8 back-pressure, R10 token while busy
        cur_req = "R8";
        wr_reg(1, 0);
        tx_ready = 0; got.delete();
        token(); cyc();
        tok_in = 1; cyc(); tok_in = 0; cyc();
        chk("R4", "zlp valid", int'(tx_valid), 1);
        chk("R4", "zlp pid", int'(tx_data), 8'h4B);
        chk("R4", "zlp last", int'(tx_last), 1);
        drain();
        chk("R10", "one byte despite extra token", got.size(), 1);

        // R6: silent host, retransmit unchanged
        cur_req = "R6";
        ticks(16); cyc();
        chk("R6", "toggle kept", int'(ep_toggle), 1);
        chk("R6", "nack kept", int'(ep_nack), 0);
        chk("R6", "irq kept", int'(irq), 0);
        got.delete(); token(); drain();
        chk("R6", "resend pid", got.size() == 1 ? int'(got[0]) : -1, 9'h14B);

        // R7: ACK on the final tick still accepted
        cur_req = "R7";
        ticks(15);
        bit_tick = 1; hs_ack = 1; cyc(); bit_tick = 0; hs_ack = 0; cyc();
        chk("R7", "ack on last tick", int'(ep_toggle), 0);
        chk("R7", "irq on last tick", int'(irq), 1);

        // R10: stray ACK while idle
        cur_req = "R10";
        hs_ack = 1; cyc(); hs_ack = 0; cyc();
        chk("R10", "stray ack ignored", int'(ep_toggle), 0);

        // R7: clamp high -> 18 ticks of window
        cur_req = "R7";
        wr_reg(2, 8'd200);
        wr_reg(0, 8'h08); wr_reg(1, 2);
        token(); drain();
        ticks(17); cyc(); cyc();
        hs_ack = 1; cyc(); hs_ack = 0; cyc();
        chk("R7", "window 18 ack accepted", int'(ep_toggle), 1);
        // clamp low -> 16 ticks of window, late ACK dropped
        wr_reg(2, 8'd3);
        wr_reg(0, 8'h0C);
        token(); drain();
        ticks(16);
        hs_ack = 1; cyc(); hs_ack = 0; cyc();
        chk("R7", "late ack dropped", int'(ep_toggle), 1);
        chk("R7", "nack still open", int'(ep_nack), 0);

        // R11: count clamp to DEPTH, full buffer
        cur_req = "R11";
        for (int i = 0; i < DEPTH; i++) wr_buf(i, 8'(i) ^ 8'h5A);
        wr_reg(1, 8'd100);
        got.delete(); token(); drain();
        chk("R11", "full packet size", got.size(), DEPTH + 1);
        if (got.size() == DEPTH + 1)
            chk("R11", "final byte", int'(got[DEPTH]), int'({1'b1, 8'(DEPTH - 1) ^ 8'h5A}));
        hs_ack = 1; cyc(); hs_ack = 0; cyc();
        chk("R5", "toggle after full packet", int'(ep_toggle), 0);

        repeat (3) cyc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule